// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block sits beside one processor core and decides which of 256 interrupt vectors the core should take next. It holds three 256-bit state arrays, one bit per vector: a pending array, an in-service array and a trigger-mode array. Each array is organised as 32-bit words. Interrupt sources post a vector together with its trigger mode. The block finds the highest pending and highest in-service vectors and derives a processor priority from them and from a task-priority input. From these it drives a single request line to the core.

The core answers the request with an acknowledge strobe. In the same cycle the block returns a vector, and at the clock edge it moves that vector from pending to in-service. When a handler finishes, the core pulses end-of-interrupt, which retires the highest in-service vector. A 9-bit configuration register holds the software-enable bit and the spurious vector. The spurious vector is returned whenever an acknowledge cannot be granted.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Priority is the vector number, so a higher number wins. The vector granted on acknowledge is always the highest-numbered pending bit of the 256-bit pending array.
- R2: A post sets the pending bit of `post_vec`. In the same cycle, `post_new` is 1 exactly when that bit was clear before the post, and 0 when the vector was already pending.
- R3: A post records the trigger mode of `post_vec`: `post_level`=1 marks the vector level-triggered and 0 marks it edge-triggered. `ack_level` is the recorded mode of the vector being granted, and 0 when no vector is granted.
- R4: `irq` is 1 only when the enable bit (bit 8 of the configuration register) is 1 and at least one vector is pending.
- R5: The processor priority is derived as follows. It equals `tpr` when nothing is in service, or when `tpr[7:4]` is at least the class (bits 7:4) of the highest in-service vector; otherwise it is that class with its low four bits zero. When the processor priority is nonzero, `irq` stays 0 while the class of the highest pending vector is less than or equal to the class of the processor priority.
- R6: An acknowledge is refused when the unit is disabled, when nothing is pending, or when `tpr` is nonzero and the highest pending vector is less than or equal to `tpr`. A refused acknowledge returns bits 7:0 of the configuration register on `ack_vec` and changes no state.
- R7: A granted acknowledge returns the highest pending vector on `ack_vec`, clears its pending bit and sets its in-service bit at the next clock edge.
- R8: End-of-interrupt clears only the highest set in-service bit. With no bit in service it has no effect.
- R9: The configuration register keeps bits 8:0 of `cfg_wdata` and ignores the bits above them. It resets to 0x0FF, so after reset the unit is disabled and its spurious vector is 0xFF.
- R10: All outputs are combinational from the current state. Posts, acknowledges, end-of-interrupt and register writes take effect at the next clock edge. When a post and an acknowledge hit the same vector in one cycle, the vector remains pending. When end-of-interrupt and a grant hit the same vector, it remains in service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid | input | 1 | Post a vector this cycle |
| post_vec | input | 8 | Vector being posted |
| post_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| tpr | input | 8 | Task priority |
| cfg_we | input | 1 | Write the configuration register |
| cfg_wdata | input | 32 | Write data; bit 8 is enable, bits 7:0 are the spurious vector |
| ack | input | 1 | Core acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| irq | output | 1 | Interrupt request to the core |
| ack_vec | output | 8 | Vector returned to an acknowledge |
| ack_level | output | 1 | Trigger mode of the granted vector |
| post_new | output | 1 | Posted vector was not already pending |

## Verification
The bench targets the cases where task priority and in-service class disagree.

- A pending vector in the same class as the in-service one must stay silent. A design that compared full vectors instead of classes would raise `irq` early.
- A pending vector above `tpr` but in the same class must be granted on acknowledge even though `irq` is low. A design that reused the request gating for acknowledge would return the spurious vector there.
- End-of-interrupt with two vectors in service must retire only the higher one. A design that cleared the lowest, or all of them, would reopen the request too soon.
- End-of-interrupt with nothing in service must change nothing.
- When a post and an acknowledge hit the same vector in one cycle, the vector must stay pending.
- Register writes with upper bits set must show that only nine bits are kept.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int VEC_W = 8;

  function automatic logic [VEC_W-1:0] proc_priority(
      input logic [VEC_W-1:0] task_pri,
      input logic             svc_any,
      input logic [VEC_W-1:0] svc_top);
    if (!svc_any || (task_pri[7:4] >= svc_top[7:4]))
      return task_pri;
    return {svc_top[7:4], 4'h0};
  endfunction

  function automatic logic class_masked(
      input logic [VEC_W-1:0] ppr,
      input logic [VEC_W-1:0] pend_top);
    return (ppr != '0) && (pend_top[7:4] <= ppr[7:4]);
  endfunction

  function automatic logic ack_refused(
      input logic [VEC_W-1:0] task_pri,
      input logic [VEC_W-1:0] pend_top);
    return (task_pri != '0) && (pend_top <= task_pri);
  endfunction

endpackage

// File: rtl/irq_hi_find.sv
module irq_hi_find #(
  parameter int N  = 256,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vec_bank.sv
module irq_vec_bank #(
  parameter int N      = 256,
  parameter int WORD_W = 32,
  localparam int WORDS = N / WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_mask,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] q
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q <= '0;
      else
        word_q <= (word_q & ~clr_mask[w*WORD_W +: WORD_W])
                | set_mask[w*WORD_W +: WORD_W];
    end
    assign q[w*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  parameter int DATA_W  = 32,
  parameter int CFG_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post_valid,
  input  logic [7:0]        post_vec,
  input  logic              post_level,
  input  logic [7:0]        tpr,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              ack,
  input  logic              eoi,
  output logic              irq,
  output logic [7:0]        ack_vec,
  output logic              ack_level,
  output logic              post_new
);
  import irq_prio_pkg::*;

  localparam int VW = $clog2(NUM_VEC);
  localparam logic [NUM_VEC-1:0] ONE = {{(NUM_VEC-1){1'b0}}, 1'b1};
  localparam logic [CFG_W-1:0] CFG_RST = CFG_W'(9'h0FF);

  logic [CFG_W-1:0] cfg_q;
  logic             sv_en;
  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic             irr_any, isr_any;
  logic [VW-1:0]    irr_top, isr_top;
  logic [7:0]       ppr;
  logic             pend_masked, ack_grant;
  logic [NUM_VEC-1:0] post_oh, grant_oh, retire_oh;
  logic [NUM_VEC-1:0] lvl_set, lvl_clr;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cfg_q <= CFG_RST;
    else if (cfg_we)
      cfg_q <= cfg_wdata[CFG_W-1:0];
  end
  assign sv_en = cfg_q[8];

  irq_hi_find #(.N(NUM_VEC)) u_find_irr (.bits(irr_q), .found(irr_any), .idx(irr_top));
  irq_hi_find #(.N(NUM_VEC)) u_find_isr (.bits(isr_q), .found(isr_any), .idx(isr_top));

  assign ppr         = proc_priority(tpr, isr_any, isr_top);
  assign pend_masked = class_masked(ppr, irr_top);
  assign irq         = sv_en && irr_any && !pend_masked;

  assign ack_grant = ack && sv_en && irr_any && !ack_refused(tpr, irr_top);
  assign ack_vec   = ack_grant ? irr_top : cfg_q[7:0];
  assign ack_level = ack_grant && tmr_q[irr_top];
  assign post_new  = post_valid && !irr_q[post_vec];

  assign post_oh   = post_valid ? (ONE << post_vec) : '0;
  assign grant_oh  = ack_grant ? (ONE << irr_top) : '0;
  assign retire_oh = (eoi && isr_any) ? (ONE << isr_top) : '0;
  assign lvl_set   = post_level ? post_oh : '0;
  assign lvl_clr   = post_level ? '0 : post_oh;

  irq_vec_bank #(.N(NUM_VEC), .WORD_W(WORD_W)) u_irr (
    .clk(clk), .rst_n(rst_n), .set_mask(post_oh), .clr_mask(grant_oh), .q(irr_q));
  irq_vec_bank #(.N(NUM_VEC), .WORD_W(WORD_W)) u_isr (
    .clk(clk), .rst_n(rst_n), .set_mask(grant_oh), .clr_mask(retire_oh), .q(isr_q));
  irq_vec_bank #(.N(NUM_VEC), .WORD_W(WORD_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .set_mask(lvl_set), .clr_mask(lvl_clr), .q(tmr_q));

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
  parameter int N = 256
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq,
  input logic         sv_en,
  input logic         irr_any,
  input logic         isr_any,
  input logic         ack,
  input logic         ack_grant,
  input logic [7:0]   ack_vec,
  input logic         eoi,
  input logic         post_valid,
  input logic [7:0]   post_vec,
  input logic [N-1:0] irr_q,
  input logic [N-1:0] isr_q
);
  AST_IRQ_NEEDS_EN_AND_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sv_en && irr_any)); // R4

  AST_REFUSED_ACK_KEEPS_IRR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ack_grant && !post_valid) |=> $stable(irr_q)); // R6

  AST_GRANT_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_grant |=> isr_q[$past(ack_vec)]); // R7

  AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && isr_any && !ack_grant) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1)); // R8

  AST_EOI_EMPTY_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !isr_any && !ack_grant) |=> $stable(isr_q)); // R8

  AST_POST_STAYS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    post_valid |=> irr_q[$past(post_vec)]); // R10
endmodule

bind irq_prio_ctrl irq_prio_chk #(.N(NUM_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .sv_en(sv_en), .irr_any(irr_any),
  .isr_any(isr_any), .ack(ack), .ack_grant(ack_grant), .ack_vec(ack_vec),
  .eoi(eoi), .post_valid(post_valid), .post_vec(post_vec),
  .irr_q(irr_q), .isr_q(isr_q));

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic post_valid = 1'b0, post_level = 1'b0, cfg_we = 1'b0, ack = 1'b0, eoi = 1'b0;
  logic [7:0] post_vec = '0, tpr = '0;
  logic [31:0] cfg_wdata = '0;
  logic irq, ack_level, post_new;
  logic [7:0] ack_vec;

  int checks = 0, fails = 0;
  bit done = 0;

  bit [255:0] m_irr, m_isr, m_tmr;
  bit [8:0]   m_cfg;

  always #4 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_vec(post_vec),
    .post_level(post_level), .tpr(tpr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ack(ack), .eoi(eoi), .irq(irq), .ack_vec(ack_vec), .ack_level(ack_level),
    .post_new(post_new));

  function automatic int top_bit(input bit [255:0] v);
    for (int i = 255; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit pv, input int pvec, input bit plv, input bit a,
                     input bit e, input bit sw, input logic [31:0] sd,
                     input int t, input string tag);
    int hp, hs, ppr;
    bit en, grant, e_irq;
    int e_vec;
    bit [255:0] n_irr, n_isr, n_tmr;
    bit [8:0] n_cfg;
    @(negedge clk);
    post_valid = pv; post_vec = pvec[7:0]; post_level = plv;
    ack = a; eoi = e; cfg_we = sw; cfg_wdata = sd; tpr = t[7:0];
    #1;
    hp = top_bit(m_irr); hs = top_bit(m_isr); en = m_cfg[8];
    if (hs < 0 || (t / 16) >= (hs / 16)) ppr = t;
    else ppr = (hs / 16) * 16;
    e_irq = en && (hp >= 0) && !(ppr != 0 && (hp / 16) <= (ppr / 16));
    grant = a && en && (hp >= 0) && !(t != 0 && hp <= t);
    e_vec = grant ? hp : int'(m_cfg[7:0]);
    chk(irq === e_irq, {"R4 R5 irq ", tag}, int'(irq), int'(e_irq));
    if (a) begin
      chk(ack_vec === e_vec[7:0], grant ? {"R7 R1 ack_vec ", tag} : {"R6 ack_vec ", tag},
          int'(ack_vec), e_vec);
      chk(ack_level === (grant && m_tmr[hp]), {"R3 ack_level ", tag},
          int'(ack_level), int'(grant && m_tmr[hp]));
    end
    if (pv) chk(post_new === !m_irr[pvec], {"R2 post_new ", tag},
                int'(post_new), int'(!m_irr[pvec]));
    n_irr = m_irr; n_isr = m_isr; n_tmr = m_tmr; n_cfg = m_cfg;
    if (grant) n_irr[hp] = 1'b0;
    if (pv) begin n_irr[pvec] = 1'b1; n_tmr[pvec] = plv; end
    if (e && hs >= 0) n_isr[hs] = 1'b0;
    if (grant) n_isr[hp] = 1'b1;
    if (sw) n_cfg = sd[8:0];
    @(posedge clk);
    m_irr = n_irr; m_isr = n_isr; m_tmr = n_tmr; m_cfg = n_cfg;
  endtask

  task automatic idle(input int t, input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, t, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    m_irr = '0; m_isr = '0; m_tmr = '0; m_cfg = 9'h0FF;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R9: reset value disabled, spurious 0xFF
    cyc(0, 0, 0, 1, 0, 0, 0, 0, "R9 reset");
    // R4: pending but disabled gives no request
    cyc(1, 'h40, 0, 0, 0, 0, 0, 0, "R4 post disabled");
    idle(0, "R4 disabled");
    cyc(1, 'h40, 0, 1, 0, 0, 0, 0, "R6 disabled ack");
    // R9: upper bits ignored, enable set, spurious 0x3A
    cyc(0, 0, 0, 0, 0, 1, 32'hFFFF_FD3A, 0, "R9 write");
    idle(0, "R4 enabled");
    // R1 R3: highest wins, trigger mode reported
    cyc(1, 'h41, 1, 0, 0, 0, 0, 0, "R3 level");
    cyc(1, 'h30, 0, 0, 0, 0, 0, 0, "R3 edge");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, "R1 ack 41");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, "R1 ack 40");
    // R5: class 3 masked by in-service class 4
    idle(0, "R5 isr class");
    // R8: eoi retires only highest
    cyc(0, 0, 0, 0, 1, 0, 0, 0, "R8 eoi 41");
    idle(0, "R8 40 still in service");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, "R8 eoi 40");
    idle(0, "R8 reopened");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, "R8 eoi empty");
    idle(0, "R8 empty no effect");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, "R7 ack 30");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, "R8 retire 30");
    // R6 R5: task priority threshold
    cyc(1, 'h45, 0, 0, 0, 0, 0, 'h45, "R5 tpr post");
    cyc(0, 0, 0, 1, 0, 0, 0, 'h45, "R6 equal tpr");
    idle('h45, "R6 no state change");
    cyc(1, 'h4F, 1, 0, 0, 0, 0, 'h45, "R5 same class");
    cyc(0, 0, 0, 1, 0, 0, 0, 'h45, "R6 above tpr granted");
    cyc(0, 0, 0, 0, 1, 0, 0, 'h45, "R8 eoi 4F");
    cyc(0, 0, 0, 1, 0, 0, 0, 'h30, "R7 lower tpr");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, "R8 eoi 45");
    // R10: same-cycle post and ack to one vector
    cyc(1, 'h90, 0, 0, 0, 0, 0, 0, "R10 post 90");
    cyc(1, 'h90, 1, 1, 0, 0, 0, 0, "R10 post+ack");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, "R10 still pending");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, "R8 eoi");
    // R2: repost of pending vector
    cyc(1, 'h22, 0, 0, 0, 0, 0, 0, "R2 first");
    cyc(1, 'h22, 0, 0, 0, 0, 0, 0, "R2 repeat");
    cyc(0, 0, 0, 0, 0, 1, 32'h0A5, 0, "R9 disable");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, "R6 disabled spurious");
    cyc(0, 0, 0, 0, 0, 1, 32'h1FF, 0, "R9 enable");
    cyc(0, 0, 0, 1, 1, 0, 0, 0, "R7 R8 ack+eoi");
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int t;
      t = ($urandom % 4 == 0) ? int'($urandom % 256) : 0;
      cyc($urandom % 2 == 0, int'($urandom % 256), $urandom % 2 == 1,
          $urandom % 4 == 0, $urandom % 4 == 0, $urandom % 64 == 0,
          ($urandom % 8 == 0) ? $urandom : 32'h0000_01F7, t, "R10 mixed");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule